// File: doc/BRIEF.md
# Lane-Parallel Integer/Float Format Converter

This block changes the number format of a vector of `LANES` 32-bit words in one registered step. A single opcode bit picks the direction for the whole vector. Widening turns each lane's signed 32-bit integer into an IEEE-754 single-precision value. Narrowing turns each lane's single-precision value into a signed 8-bit integer. The narrowing path rounds first and then clips to the 8-bit range.

A typical use is after an integer multiply-accumulate array. Accumulator sums are widened to float and scaled elsewhere. They are then narrowed back to bytes for the next layer, without leaving the chip. A command is presented with `in_valid`, and its result appears one clock later with `out_valid`. Every lane is converted at the same time.

Top module: `conv_array`

## Requirements
- R1: While `rst_n` is low, `out_valid` is 0 and `out_data` is all zeros.
- R2: A command accepted with `in_valid` high at a rising edge produces `out_valid` high after that edge, for exactly one cycle. `out_valid` is low after any edge at which `in_valid` was low.
- R3: With `in_op` = 0 (widen), each lane's signed 32-bit integer becomes its single-precision bit pattern. The result is exact whenever |x| ≤ 2^24. For example, 50 gives 0x42480000, 0 gives 0x00000000 and -2^31 gives 0xCF000000.
- R4: When widening an integer with |x| > 2^24, the 24-bit significand is rounded to nearest, with ties to even. For example, 16777217 gives 0x4B800000, 16777219 gives 0x4B800002 and 2^31-1 gives 0x4F000000.
- R5: With `in_op` = 1 (narrow), each lane's float is rounded to the nearest integer, with ties away from zero. So 0.5 gives 1, -0.5 gives -1, 2.5 gives 3 and -2.5 gives -3. Magnitudes below 0.5, including zeros and subnormals, give 0.
- R6: After rounding, a narrowed value above 127 becomes 127 and one below -128 becomes -128. Infinities take the limit of their sign.
- R7: Any NaN input to narrowing (exponent all ones, fraction non-zero) gives 0.
- R8: A narrowed result sits in bits 7:0 of its lane as two's complement, and bits 31:8 of that lane are zero.
- R9: Lanes are independent. Lane i of `in_data` (bits 32i+31:32i) only sets lane i of `out_data`, and all lanes are converted by the same command.
- R10: `out_data` keeps its previous value after any edge at which `in_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A command is present this cycle |
| in_op | input | 1 | 0 = widen integer to float, 1 = narrow float to byte |
| in_data | input | 32*LANES | Source words, lane i at bits 32i+31:32i |
| out_valid | output | 1 | Result of the previous cycle's command is present |
| out_data | output | 32*LANES | Converted words, same lane layout |

## Verification
Two functions can fall in the same cycle. The first case is the retiring of one command and the acceptance of the next one in the other direction. It is provoked by issuing widen and narrow commands back to back with no idle cycle, and by mixing idle gaps in between. Each output cycle is then judged against the op of the command one cycle earlier, not the current one. The second case is rounding and clipping in one lane at once, as with 127.5 or -128.5, where the rounding carry is what pushes the value out of range. A behavioural reference that uses the simulator's real arithmetic judges both cases on every clock.

// File: rtl/conv_pkg.sv
package conv_pkg;

  localparam int WORD_W = 32;

  typedef enum logic {OP_WIDEN = 1'b0, OP_NARROW = 1'b1} conv_op_e;

  typedef struct packed {
    logic [7:0] val;
    logic       clip;
    logic       nan;
  } narrow_t;

  // signed int32 -> binary32, round to nearest even
  function automatic logic [31:0] int_to_f32(input logic [31:0] x);
    logic        sgn;
    logic [31:0] mag;
    logic [31:0] mask;
    logic [24:0] kept;
    logic [7:0]  ex;
    logic        grd;
    logic        stk;
    int          msb;
    int          sh;
    if (x == 32'd0) return 32'd0;
    sgn = x[31];
    mag = sgn ? (~x + 32'd1) : x;
    msb = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) msb = i;
    if (msb <= 23) begin
      kept = 25'(mag << (23 - msb));
    end else begin
      sh   = msb - 23;
      kept = 25'(mag >> sh);
      grd  = mag[sh-1];
      mask = (32'd1 << (sh - 1)) - 32'd1;
      stk  = |(mag & mask);
      if (grd && (stk || kept[0])) kept = kept + 25'd1;
    end
    ex = 8'(127 + msb);
    if (kept[24]) begin
      ex   = ex + 8'd1;
      kept = kept >> 1;
    end
    return {sgn, ex, kept[22:0]};
  endfunction

  // binary32 -> int8, round half away from zero, then clip
  function automatic narrow_t f32_to_s8(input logic [31:0] f);
    narrow_t     r;
    logic        s;
    logic [7:0]  e;
    logic [23:0] sig;
    logic [8:0]  mag;
    int          sh;
    s   = f[31];
    e   = f[30:23];
    sig = {1'b1, f[22:0]};
    r   = '0;
    if (e == 8'hFF) begin
      if (f[22:0] != 23'd0) r.nan = 1'b1;
      else begin
        r.clip = 1'b1;
        r.val  = s ? 8'h80 : 8'h7F;
      end
    end else if (e > 8'd134) begin
      r.clip = 1'b1;
      r.val  = s ? 8'h80 : 8'h7F;
    end else if (e >= 8'd126) begin
      sh  = 150 - int'(e);
      mag = 9'(sig >> sh) + {8'd0, sig[sh-1]};
      if (s) begin
        r.clip = (mag > 9'd128);
        r.val  = r.clip ? 8'h80 : 8'(~mag + 9'd1);
      end else begin
        r.clip = (mag > 9'd127);
        r.val  = r.clip ? 8'h7F : mag[7:0];
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cvt_widen.sv
module cvt_widen (
  input  logic [31:0] src,
  output logic [31:0] dst
);
  always_comb dst = conv_pkg::int_to_f32(src);
endmodule

// File: rtl/cvt_narrow.sv
module cvt_narrow (
  input  logic [31:0] src,
  output logic [7:0]  dst,
  output logic        clip,
  output logic        nan
);
  conv_pkg::narrow_t res;
  always_comb begin
    res  = conv_pkg::f32_to_s8(src);
    dst  = res.val;
    clip = res.clip;
    nan  = res.nan;
  end
endmodule

// File: rtl/conv_lane.sv
module conv_lane (
  input  logic        op,
  input  logic [31:0] src,
  output logic [31:0] dst,
  output logic        clip,
  output logic        nan
);
  logic [31:0] wide_q;
  logic [7:0]  byte_q;

  cvt_widen  u_widen  (.src(src), .dst(wide_q));
  cvt_narrow u_narrow (.src(src), .dst(byte_q), .clip(clip), .nan(nan));

  always_comb dst = (op == conv_pkg::OP_NARROW) ? {24'd0, byte_q} : wide_q;
endmodule

// File: rtl/conv_array.sv
module conv_array #(
  parameter int LANES = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  input  logic                            in_op,
  input  logic [LANES*conv_pkg::WORD_W-1:0] in_data,
  output logic                            out_valid,
  output logic [LANES*conv_pkg::WORD_W-1:0] out_data
);
  localparam int W   = conv_pkg::WORD_W;
  localparam int VEC = LANES * W;

  logic [VEC-1:0]   next_data;
  logic [LANES-1:0] lane_clip;
  logic [LANES-1:0] lane_nan;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    conv_lane u_lane (
      .op   (in_op),
      .src  (in_data[g*W +: W]),
      .dst  (next_data[g*W +: W]),
      .clip (lane_clip[g]),
      .nan  (lane_nan[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= next_data;
    end
  end
endmodule

// File: rtl/conv_array_chk.sv
module conv_array_chk #(
  parameter int LANES = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  in_valid,
  input logic                  in_op,
  input logic [LANES*32-1:0]   in_data,
  input logic                  out_valid,
  input logic [LANES*32-1:0]   out_data,
  input logic [LANES-1:0]      lane_clip,
  input logic [LANES-1:0]      lane_nan
);
  logic upper_any;
  always_comb begin
    upper_any = 1'b0;
    for (int i = 0; i < LANES; i++) upper_any = upper_any | (|out_data[i*32+8 +: 24]);
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
  assert_zero_widen_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_op && in_data[31:0] == 32'd0) |=> out_data[31:0] == 32'd0);
  assert_clip_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op && lane_clip[0]) |=>
      out_data[7:0] == ($past(in_data[31]) ? 8'h80 : 8'h7F));
  assert_nan_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op && lane_nan[0]) |=> out_data[7:0] == 8'h00);
  assert_upper_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_op) |=> !upper_any);
endmodule

bind conv_array conv_array_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op), .in_data(in_data),
  .out_valid(out_valid), .out_data(out_data), .lane_clip(lane_clip), .lane_nan(lane_nan)
);

// File: tb/tb_conv_array.sv
module tb_conv_array;
  localparam int N = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_op = 1'b0;
  logic [N*32-1:0] in_data = '0;
  logic          out_valid;
  logic [N*32-1:0] out_data;

  int    n_checks = 0;
  int    n_fail = 0;
  string cur_tag = "R10";
  string exp_tag = "R1";
  logic  exp_v = 1'b0;
  logic [N*32-1:0] exp_d = '0;

  conv_array #(.LANES(N)) dut (.*);

  always #4 clk = ~clk;

  // reference: int32 -> double (exact) -> float with nearest-even
  function automatic logic [31:0] ref_widen(input logic [31:0] x);
    real r; logic [63:0] b; int fe; logic [23:0] t;
    if (x == 0) return 32'd0;
    r  = $itor($signed(x));
    b  = $realtobits(r);
    fe = int'(b[62:52]) - 1023 + 127;
    t  = {1'b0, b[51:29]};
    if (b[28] && ((|b[27:0]) || t[0])) t = t + 24'd1;
    if (t[23]) begin fe = fe + 1; t = 24'd0; end
    return {b[63], 8'(fe), t[22:0]};
  endfunction

  // reference: float -> real -> rounded, clipped byte
  function automatic logic [31:0] ref_narrow(input logic [31:0] f);
    real r; int v; int e;
    e = int'(f[30:23]);
    if (e == 255) begin
      if (f[22:0] != 0) return 32'd0;
      return f[31] ? 32'h80 : 32'h7F;
    end
    if (e == 0) return 32'd0;
    r = $bitstoreal({f[31], 11'(e + 896), f[22:0], 29'd0});
    if (r >= 127.5) v = 127;
    else if (r <= -128.5) v = -128;
    else if (r >= 0.0) v = $rtoi(r + 0.5);
    else v = -$rtoi(-r + 0.5);
    if (v < -128) v = -128;
    return {24'd0, 8'(v)};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_v <= 1'b0; exp_d <= '0; exp_tag <= "R1";
    end else begin
      exp_v <= in_valid;
      if (in_valid) begin
        for (int i = 0; i < N; i++)
          exp_d[i*32 +: 32] <= in_op ? ref_narrow(in_data[i*32 +: 32]) : ref_widen(in_data[i*32 +: 32]);
        exp_tag <= cur_tag;
      end else exp_tag <= "R10";
    end
  end

  task automatic check(input string tag, input logic [N*32-1:0] act, input logic [N*32-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check("R2", {{(N*32-1){1'b0}}, out_valid}, {{(N*32-1){1'b0}}, exp_v});
    check(exp_tag, out_data, exp_d);
  end

  task automatic cmd(input logic op, input logic [N*32-1:0] d, input string tag);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_data = d; cur_tag = tag;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0; in_data = '1; in_op = 1'b1;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {{(N*32-1){1'b0}}, out_valid}, '0);
    check("R1", out_data, '0);
    rst_n = 1'b1;
    idle(2);
    // R3 exact widening
    cmd(0, {32'd0, 32'd50, -32'sd50, 32'd1, -32'sd1, 32'd16777216, -32'sd16777216, 32'h80000000}, "R3");
    idle(1);
    // R4 nearest-even widening
    cmd(0, {32'd16777217, 32'd16777219, 32'h7FFFFFFF, -32'sd16777217,
            32'd33554435, 32'd16777218, 32'h7FFFFFC0, 32'd123456789}, "R4");
    // R5 rounding, back to back with the op switched
    cmd(1, {32'h3F000000, 32'hBF000000, 32'h40200000, 32'hC0200000,
            32'h3FC00000, 32'h3EFFFFFF, 32'h00000000, 32'h80000000}, "R5");
    cmd(1, {32'h3F800000, 32'hBF800000, 32'h42C80000, 32'hC2C96666,
            32'h00000001, 32'h3F7FFFFF, 32'h40400000, 32'hBFC00000}, "R5");
    idle(2);
    // R6 clipping, including rounding carry into range edge
    cmd(1, {32'h42FECCCD, 32'h42FF0000, 32'hC3000000, 32'hC3008000,
            32'h4E6E6B28, 32'h7F800000, 32'hFF800000, 32'h43960000}, "R6");
    // R7 NaNs mixed with ordinary values
    cmd(1, {32'h7FC00000, 32'hFFC00001, 32'h7F800001, 32'h42C80000,
            32'hFFFFFFFF, 32'h3F000000, 32'h7FFFFFFF, 32'hC2FE0000}, "R7");
    // R8 negative results leave upper bits clear
    cmd(1, {8{32'hC1200000}}, "R8");
    // R9 distinct lanes, alternating ops with no gap
    cmd(0, {32'd7, 32'd70000, -32'sd3, 32'd255, 32'd1000000, -32'sd99, 32'd2, 32'd40000000}, "R9");
    cmd(1, {32'h40E00000, 32'hC0400000, 32'h437F0000, 32'h3E800000,
            32'h41200000, 32'hC2C60000, 32'h40000000, 32'h47000000}, "R9");
    cmd(0, {32'd42, 32'd43, 32'd44, 32'd45, 32'd46, 32'd47, 32'd48, 32'd49}, "R9");
    // R10 hold across idle cycles with garbage inputs
    idle(4);
    cmd(1, {32'h3F000000, 32'h3F000000, 32'h3F000000, 32'h3F000000,
            32'h3F000000, 32'h3F000000, 32'h3F000000, 32'h3F000000}, "R5");
    idle(3);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule